// File: doc/BRIEF.md
# Programmable External Bus Cycle Sequencer

This block runs the cycles of a microcontroller's external memory bus: instruction fetches, data reads and data writes. It drives an address latch strobe, a program-store enable, a read strobe and a write strobe, along with a multiplexed address/data bus. A request may include an address phase, where the address is latched externally, or omit it for sequential accesses that reuse the address already latched. The block is clocked at twice the bus reference rate. Every phase length is a whole number of half-cycles, one per block clock.

Phase lengths come from two configuration bytes that describe bus timing. At request acceptance the block derives the lengths of up to five phases: address (latch strobe high), address hold gap, write setup, strobe, and write data hold. It keeps those lengths for the rest of the cycle, so a change to the configuration takes effect from the next request. A single down-counter times each phase. A phase whose length works out to zero is skipped. The WAIT input freezes the counter while a strobe is active.

The state machine has seven states: IDLE, ADDR, GAP, SETUP, STRB, HOLD and DONE. Its transitions are:
- IDLE to the first phase of nonzero length when a request is accepted.
- ADDR to GAP.
- GAP to SETUP, or to STRB if there is no setup.
- SETUP to STRB.
- STRB to HOLD, or to DONE if there is no hold.
- HOLD to DONE.
- DONE to IDLE, always after one cycle.

Every other state except STRB moves on when its counter reaches zero. STRB moves on only when its counter reaches zero and WAIT is low.

Top module: `bus_seq_top`

## Requirements
- R1: Configuration low byte bit 5 (A) sets the address phase. When the request's address-phase flag is 1, the latch strobe is high for 2*A+1 half-cycles from the first cycle after acceptance. When the flag is 0 it stays low. Low byte bit 4 is ignored.
- R2: Fetch (kind 00) with address phase: the cycle lasts 4+2*low[1:0] half-cycles. The program-store enable goes low one half-cycle after the latch strobe falls and stays low for the rest of the cycle, and never for less than one half-cycle.
- R3: Fetch without address phase: the program-store enable is low for the whole cycle of 2+2*low[3:2] half-cycles.
- R4: Read (kind 01, and also kind 11) with address phase: the cycle lasts 4+2*high[1:0] half-cycles. The read strobe follows the same rule as R2.
- R5: Read without address phase: the read strobe is low for the whole cycle of 2+2*high[3:2] half-cycles.
- R6: Write (kind 10): the write strobe is low for 2+2*low[7] half-cycles. Write data is then still driven for 2*low[6] half-cycles.
- R7: Write with address phase: the cycle lasts 4+2*high[5:4] half-cycles. The setup before the write strobe is max(1, total minus strobe, hold and latch widths) half-cycles. Its first half-cycle still drives the address.
- R8: Write without address phase: the cycle lasts 4+2*high[7:6] half-cycles. The setup is max(1, total minus strobe and hold widths) half-cycles, with data driven.
- R9: Each clock on which WAIT is sampled high while a strobe is low lengthens that strobe by one half-cycle. The other phases keep their lengths.
- R10: Read data is captured from the bus input on the clock edge that ends the strobe. It is presented on the response data port while done is high.
- R11: After reset all strobes are inactive and the bus is not driven. Acknowledge is high only in IDLE while a request is present. Done is a one-cycle pulse in the cycle after the final phase.
- R12: Only the strobe belonging to the request kind ever asserts, and never while the latch strobe is high.
- R13: The bus carries the address while the latch strobe is high and during the gap. For a write it carries the data during setup, strobe and hold. It is not driven during a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus reference rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lo | input | 8 | Timing configuration low byte |
| cfg_hi | input | 8 | Timing configuration high byte |
| req | input | 1 | Transaction request |
| req_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 read |
| req_ale | input | 1 | 1 = include address phase |
| req_addr | input | AW | Transaction address |
| req_wdata | input | DW | Write data |
| ack | output | 1 | Request accepted this cycle |
| rsp_rdata | output | DW | Captured read data |
| rsp_done | output | 1 | One-cycle completion pulse |
| bus_ale | output | 1 | Address latch strobe, active high |
| bus_psen_n | output | 1 | Program-store enable, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_ad | output | AW | Multiplexed address/data out |
| bus_ad_oe | output | 1 | Output enable for bus_ad |
| bus_din | input | DW | Data in from the bus |
| bus_wait | input | 1 | Wait request, active high |

## Verification
The assertions check the cycle-local rules on every clock:
- at most one strobe at a time;
- all strobes inactive in the half-cycle after the latch strobe falls;
- no drive during read strobes and drive during write strobes;
- a strobe that is held while WAIT is high;
- single-cycle done and acknowledge.

Only the bench can show that each phase has the arithmetic length its configuration fields call for. The bench sweeps those fields and computes the expected lengths itself. The same applies to the clamped minimum lengths, to the exact data word captured at strobe release, and to the total cycle length under inserted wait states.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

    localparam int LEN_W = 4;

    typedef enum logic [1:0] {
        K_FETCH    = 2'b00,
        K_READ     = 2'b01,
        K_WRITE    = 2'b10,
        K_READ_ALT = 2'b11
    } kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_GAP,
        ST_SETUP,
        ST_STRB,
        ST_HOLD,
        ST_DONE
    } state_e;

    typedef struct packed {
        logic [LEN_W-1:0] addr;
        logic [LEN_W-1:0] gap;
        logic [LEN_W-1:0] setup;
        logic [LEN_W-1:0] strb;
        logic [LEN_W-1:0] hold;
    } lens_t;

endpackage

// File: rtl/bus_seq_timing.sv
module bus_seq_timing
    import bus_seq_pkg::*;
(
    input  logic [7:0] cfg_lo,
    input  logic [7:0] cfg_hi,
    input  kind_e      kind,
    input  logic       use_ale,
    output lens_t      lens
);

    logic unused_rsvd;
    assign unused_rsvd = cfg_lo[4];

    function automatic logic [LEN_W-1:0] at_least_one(input int v);
        return (v < 1) ? LEN_W'(1) : LEN_W'(v);
    endfunction

    always_comb begin
        int latch_w;
        int tot_a;
        int tot_n;
        int strobe_w;
        int hold_w;
        int setup_w;
        latch_w  = 2 * int'(cfg_lo[5]) + 1;
        strobe_w = 2 + 2 * int'(cfg_lo[7]);
        hold_w   = 2 * int'(cfg_lo[6]);
        unique case (kind)
            K_FETCH: begin
                tot_a = 4 + 2 * int'(cfg_lo[1:0]);
                tot_n = 2 + 2 * int'(cfg_lo[3:2]);
            end
            K_WRITE: begin
                tot_a = 4 + 2 * int'(cfg_hi[5:4]);
                tot_n = 4 + 2 * int'(cfg_hi[7:6]);
            end
            default: begin
                tot_a = 4 + 2 * int'(cfg_hi[1:0]);
                tot_n = 2 + 2 * int'(cfg_hi[3:2]);
            end
        endcase
        lens = '0;
        if (kind == K_WRITE) begin
            lens.strb = LEN_W'(strobe_w);
            lens.hold = LEN_W'(hold_w);
            if (use_ale) begin
                setup_w    = int'(at_least_one(tot_a - strobe_w - hold_w - latch_w));
                lens.addr  = LEN_W'(latch_w);
                lens.gap   = LEN_W'(1);
                lens.setup = LEN_W'(setup_w - 1);
            end else begin
                lens.setup = at_least_one(tot_n - strobe_w - hold_w);
            end
        end else begin
            if (use_ale) begin
                lens.addr = LEN_W'(latch_w);
                lens.gap  = LEN_W'(1);
                lens.strb = at_least_one(tot_a - latch_w - 1);
            end else begin
                lens.strb = LEN_W'(tot_n);
            end
        end
    end

endmodule

// File: rtl/bus_seq_ctrl.sv
module bus_seq_ctrl
    import bus_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  kind_e         req_kind,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  lens_t         lens_calc,
    input  logic          bus_wait,
    input  logic [DW-1:0] bus_din,
    output state_e        state,
    output kind_e         kind_q,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] rdata_q
);

    state_e           nxt;
    lens_t            lens_q;
    lens_t            lens_use;
    logic [LEN_W-1:0] cnt;
    logic             phase_end;
    logic             stalled;

    function automatic state_e after_gap(input lens_t l);
        return (l.setup != '0) ? ST_SETUP : ST_STRB;
    endfunction

    function automatic state_e after_addr(input lens_t l);
        return (l.gap != '0) ? ST_GAP : after_gap(l);
    endfunction

    function automatic state_e first_phase(input lens_t l);
        return (l.addr != '0) ? ST_ADDR : after_addr(l);
    endfunction

    function automatic state_e after_strb(input lens_t l);
        return (l.hold != '0) ? ST_HOLD : ST_DONE;
    endfunction

    function automatic logic [LEN_W-1:0] len_of(input state_e s, input lens_t l);
        logic [LEN_W-1:0] r;
        unique case (s)
            ST_ADDR:  r = l.addr;
            ST_GAP:   r = l.gap;
            ST_SETUP: r = l.setup;
            ST_STRB:  r = l.strb;
            ST_HOLD:  r = l.hold;
            default:  r = LEN_W'(1);
        endcase
        return r;
    endfunction

    assign lens_use  = (state == ST_IDLE) ? lens_calc : lens_q;
    assign stalled   = (state == ST_STRB) && bus_wait;
    assign phase_end = (cnt == '0) && !stalled;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (req) nxt = first_phase(lens_calc);
            ST_ADDR:  if (phase_end) nxt = after_addr(lens_q);
            ST_GAP:   if (phase_end) nxt = after_gap(lens_q);
            ST_SETUP: if (phase_end) nxt = ST_STRB;
            ST_STRB:  if (phase_end) nxt = after_strb(lens_q);
            ST_HOLD:  if (phase_end) nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            lens_q  <= '0;
            kind_q  <= K_FETCH;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            state <= nxt;
            if (nxt != state) begin
                cnt <= len_of(nxt, lens_use) - LEN_W'(1);
            end else if (!stalled && cnt != '0) begin
                cnt <= cnt - LEN_W'(1);
            end
            if (state == ST_IDLE && req) begin
                lens_q  <= lens_calc;
                kind_q  <= req_kind;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (state == ST_STRB && nxt != ST_STRB && kind_q != K_WRITE) begin
                rdata_q <= bus_din;
            end
        end
    end

endmodule

// File: rtl/bus_seq_drive.sv
module bus_seq_drive
    import bus_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  state_e        state,
    input  kind_e         kind_q,
    input  logic [AW-1:0] addr_q,
    input  logic [DW-1:0] wdata_q,
    input  logic          req,
    output logic          ack,
    output logic          done,
    output logic          ale,
    output logic          psen_n,
    output logic          rd_n,
    output logic          wr_n,
    output logic [AW-1:0] ad,
    output logic          ad_oe
);

    logic [AW-1:0] wdata_ext;
    assign wdata_ext = AW'(wdata_q);

    always_comb begin
        ack    = 1'b0;
        done   = 1'b0;
        ale    = 1'b0;
        psen_n = 1'b1;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        ad     = '0;
        ad_oe  = 1'b0;
        unique case (state)
            ST_IDLE: ack = req;
            ST_ADDR: begin
                ale   = 1'b1;
                ad    = addr_q;
                ad_oe = 1'b1;
            end
            ST_GAP: begin
                ad    = addr_q;
                ad_oe = 1'b1;
            end
            ST_SETUP, ST_HOLD: begin
                ad    = wdata_ext;
                ad_oe = 1'b1;
            end
            ST_STRB: begin
                unique case (kind_q)
                    K_FETCH: psen_n = 1'b0;
                    K_WRITE: begin
                        wr_n  = 1'b0;
                        ad    = wdata_ext;
                        ad_oe = 1'b1;
                    end
                    default: rd_n = 1'b0;
                endcase
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/bus_seq_top.sv
module bus_seq_top
    import bus_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    cfg_lo,
    input  logic [7:0]    cfg_hi,
    input  logic          req,
    input  logic [1:0]    req_kind,
    input  logic          req_ale,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          ack,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_done,
    output logic          bus_ale,
    output logic          bus_psen_n,
    output logic          bus_rd_n,
    output logic          bus_wr_n,
    output logic [AW-1:0] bus_ad,
    output logic          bus_ad_oe,
    input  logic [DW-1:0] bus_din,
    input  logic          bus_wait
);

    kind_e         kind_in;
    kind_e         kind_q;
    lens_t         lens_calc;
    state_e        state;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;

    assign kind_in = kind_e'(req_kind);

    bus_seq_timing u_timing (
        .cfg_lo  (cfg_lo),
        .cfg_hi  (cfg_hi),
        .kind    (kind_in),
        .use_ale (req_ale),
        .lens    (lens_calc)
    );

    bus_seq_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_kind  (kind_in),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .lens_calc (lens_calc),
        .bus_wait  (bus_wait),
        .bus_din   (bus_din),
        .state     (state),
        .kind_q    (kind_q),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .rdata_q   (rsp_rdata)
    );

    bus_seq_drive #(.AW(AW), .DW(DW)) u_drive (
        .state   (state),
        .kind_q  (kind_q),
        .addr_q  (addr_q),
        .wdata_q (wdata_q),
        .req     (req),
        .ack     (ack),
        .done    (rsp_done),
        .ale     (bus_ale),
        .psen_n  (bus_psen_n),
        .rd_n    (bus_rd_n),
        .wr_n    (bus_wr_n),
        .ad      (bus_ad),
        .ad_oe   (bus_ad_oe)
    );

endmodule

// File: rtl/bus_seq_chk.sv
module bus_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic ack,
    input logic rsp_done,
    input logic bus_ale,
    input logic bus_psen_n,
    input logic bus_rd_n,
    input logic bus_wr_n,
    input logic bus_ad_oe,
    input logic bus_wait
);

    a_r12_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({bus_ale, !bus_psen_n, !bus_rd_n, !bus_wr_n}) <= 1);

    a_r2_gap_after_latch: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_ale) |-> (bus_psen_n && bus_rd_n && bus_wr_n));

    a_r13_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_psen_n || !bus_rd_n) |-> !bus_ad_oe);

    a_r6_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_n |-> bus_ad_oe);

    a_r9_wait_holds_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n && bus_wait) |=> !bus_rd_n);

    a_r9_wait_holds_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_psen_n && bus_wait) |=> !bus_psen_n);

    a_r9_wait_holds_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr_n && bus_wait) |=> !bus_wr_n);

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    a_r11_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

endmodule

bind bus_seq_top bus_seq_chk u_chk (.*);

// File: tb/test_bus_seq_top.sv
module test_bus_seq_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_lo = '0;
    logic [7:0]  cfg_hi = '0;
    logic        req = 1'b0;
    logic [1:0]  req_kind = '0;
    logic        req_ale = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ack;
    logic [7:0]  rsp_rdata;
    logic        rsp_done;
    logic        bus_ale, bus_psen_n, bus_rd_n, bus_wr_n, bus_ad_oe;
    logic [15:0] bus_ad;
    logic [7:0]  bus_din = '0;
    logic        bus_wait = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    bus_seq_top i_bus_seq_top (
        .clk(clk), .rst_n(rst_n), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
        .req(req), .req_kind(req_kind), .req_ale(req_ale),
        .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack),
        .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .bus_ale(bus_ale),
        .bus_psen_n(bus_psen_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_ad(bus_ad), .bus_ad_oe(bus_ad_oe), .bus_din(bus_din),
        .bus_wait(bus_wait)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic run(input logic [1:0] k, input bit a, input logic [7:0] lo,
                       input logic [7:0] hi, input logic [15:0] adr,
                       input logic [7:0] wd, input int nw, input bit keep);
        int e_addr, e_gap, e_setup, e_strb, e_hold, ta, tn, lw, sw, hw;
        int n, ale_cnt, s_start, s_cnt, hold_cnt, addr_bad, data_bad, wrong;
        int busy_ack, done_idx, waits_left, last_din, rd_val;
        bit strobe, seen_s, seen_done;
        string tag;
        lw = 2 * lo[5] + 1;
        sw = 2 + 2 * lo[7];
        hw = 2 * lo[6];
        if (k == 2'b00) begin ta = 4 + 2 * lo[1:0]; tn = 2 + 2 * lo[3:2]; end
        else if (k == 2'b10) begin ta = 4 + 2 * hi[5:4]; tn = 4 + 2 * hi[7:6]; end
        else begin ta = 4 + 2 * hi[1:0]; tn = 2 + 2 * hi[3:2]; end
        e_addr = a ? lw : 0;
        e_gap = a ? 1 : 0;
        e_setup = 0; e_hold = 0;
        if (k == 2'b10) begin
            e_strb = sw; e_hold = hw;
            if (a) begin
                e_setup = ta - sw - hw - lw;
                if (e_setup < 1) e_setup = 1;
                e_setup = e_setup - 1;
            end else begin
                e_setup = tn - sw - hw;
                if (e_setup < 1) e_setup = 1;
            end
            tag = a ? "R7" : "R8";
        end else begin
            e_strb = a ? ta - lw - 1 : tn;
            if (e_strb < 1) e_strb = 1;
            if (k == 2'b00) tag = a ? "R2" : "R3";
            else tag = a ? "R4" : "R5";
        end

        @(negedge clk);
        cfg_lo = lo; cfg_hi = hi; req = 1'b1; req_kind = k; req_ale = a;
        req_addr = adr; req_wdata = wd;
        #1;
        chk("R11", "ack in idle", int'(ack), 1);
        n = 0; ale_cnt = 0; s_start = -1; s_cnt = 0; hold_cnt = 0;
        addr_bad = 0; data_bad = 0; wrong = 0; busy_ack = 0; done_idx = -1;
        waits_left = nw; last_din = 0; seen_s = 0; seen_done = 0; rd_val = 0;
        while (!seen_done && n < 60) begin
            @(negedge clk);
            if (!keep) req = 1'b0;
            if (ack) busy_ack++;
            if (k == 2'b00) begin
                strobe = !bus_psen_n;
                if (!bus_rd_n || !bus_wr_n) wrong++;
            end else if (k == 2'b10) begin
                strobe = !bus_wr_n;
                if (!bus_rd_n || !bus_psen_n) wrong++;
            end else begin
                strobe = !bus_rd_n;
                if (!bus_psen_n || !bus_wr_n) wrong++;
            end
            if (bus_ale) begin
                ale_cnt++;
                if (!bus_ad_oe || bus_ad != adr) addr_bad++;
                if (strobe) wrong++;
            end
            if (strobe) begin
                if (!seen_s) s_start = n;
                seen_s = 1;
                s_cnt++;
                if (k == 2'b10) begin
                    if (!bus_ad_oe || bus_ad != {8'h00, wd}) data_bad++;
                end else if (bus_ad_oe) data_bad++;
            end else if (k == 2'b10 && seen_s && !rsp_done && bus_ad_oe && bus_ad == {8'h00, wd}) begin
                hold_cnt++;
            end
            if (rsp_done) begin
                seen_done = 1;
                done_idx = n;
                rd_val = int'(rsp_rdata);
                req = 1'b0;
            end
            bus_din = 8'(n * 37 + adr[7:0] + 11);
            if (strobe && waits_left > 0) begin
                bus_wait = 1'b1;
                waits_left--;
            end else bus_wait = 1'b0;
            if (strobe) last_din = int'(bus_din);
            n++;
        end
        bus_wait = 1'b0;
        chk(tag, "cycle length to done", done_idx, e_addr + e_gap + e_setup + e_strb + nw + e_hold);
        chk("R1", "latch strobe width", ale_cnt, e_addr);
        chk(tag, "strobe start", s_start, e_addr + e_gap + e_setup);
        chk(nw > 0 ? "R9" : (k == 2'b10 ? "R6" : tag), "strobe width", s_cnt, e_strb + nw);
        chk("R13", "address on bus during latch", addr_bad, 0);
        chk("R13", "bus drive during strobe", data_bad, 0);
        chk("R12", "foreign strobe activity", wrong, 0);
        chk("R11", "ack while busy", busy_ack, 0);
        if (k == 2'b10) chk("R6", "write data hold", hold_cnt, e_hold);
        else chk("R10", "captured read data", rd_val, last_din);
        @(negedge clk);
        chk("R11", "done single cycle", int'(rsp_done), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1;
        chk("R11", "reset latch strobe", int'(bus_ale), 0);
        chk("R11", "reset strobes", int'({bus_psen_n, bus_rd_n, bus_wr_n}), 7);
        chk("R11", "reset drive", int'(bus_ad_oe), 0);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        chk("R11", "idle done", int'(rsp_done), 0);

        for (int kk = 0; kk < 2; kk++) begin
            logic [1:0] kd;
            kd = (kk == 0) ? 2'b00 : 2'b01;
            for (int lw = 0; lw < 2; lw++)
                for (int f = 0; f < 4; f++) begin
                    run(kd, 1'b1, {2'b01, 1'(lw), 1'b0, 2'(3 - f), 2'(f)},
                        {4'ha, 2'(3 - f), 2'(f)}, 16'h5a00 + 16'(f * 17 + lw), 8'h00, 0, 1'b0);
                    run(kd, 1'b0, {2'b10, 1'(lw), 1'b0, 2'(f), 2'(3 - f)},
                        {4'h5, 2'(f), 2'(3 - f)}, 16'h3c00 + 16'(f * 5), 8'h00, 0, 1'b0);
                end
        end
        for (int lw = 0; lw < 2; lw++)
            for (int f = 0; f < 4; f++)
                for (int m = 0; m < 4; m++) begin
                    run(2'b10, 1'b1, {2'(m), 1'(lw), 1'b0, 4'h6},
                        {2'(3 - f), 2'(f), 4'h9}, 16'h7100 + 16'(m), 8'(8'h21 + f * 4 + m), 0, 1'b0);
                    if (lw == 0)
                        run(2'b10, 1'b0, {2'(m), 1'b1, 1'b0, 4'h3},
                            {2'(f), 2'(3 - f), 4'h0}, 16'h6200, 8'(8'h90 + f * 4 + m), 0, 1'b0);
                end
        for (int w = 1; w < 4; w++) begin
            run(2'b00, 1'b1, 8'b0000_0010, 8'h00, 16'h1234, 8'h00, w, 1'b0);
            run(2'b01, 1'b0, 8'h00, 8'b0000_1100, 16'h2345, 8'h00, w, 1'b0);
            run(2'b10, 1'b1, 8'b1110_0000, 8'b0011_0000, 16'h3456, 8'h5c, w, 1'b0);
        end
        run(2'b00, 1'b1, 8'b0011_0001, 8'h00, 16'h4400, 8'h00, 0, 1'b0);
        run(2'b00, 1'b1, 8'b0010_0001, 8'h00, 16'h4400, 8'h00, 0, 1'b0);
        run(2'b11, 1'b1, 8'b0000_0000, 8'b0000_0011, 16'h4500, 8'h00, 0, 1'b0);
        run(2'b11, 1'b0, 8'b0000_0000, 8'b0000_0100, 16'h4600, 8'h00, 0, 1'b0);
        run(2'b01, 1'b1, 8'b0010_0000, 8'b0000_0001, 16'h4700, 8'h00, 0, 1'b1);
        run(2'b10, 1'b0, 8'b1100_0000, 8'b1100_0000, 16'h4800, 8'h77, 1, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule